// File: doc/BRIEF.md
# EEPROM Block Write-Protect Controller

This block sits between the write path of a small byte-addressed register space and a 32-byte EEPROM array split into two 16-byte blocks. Every write request passes through a gate. The gate drops writes to the array while a copy of data to nonvolatile storage is in progress. It also drops writes to any block that has been locked. Writes to addresses outside the array pass through unchanged.

A control register at address 07h reports the block state and holds a one-shot arming bit for the lock command. A lock command only takes effect while the arming bit is set. The command then marks the block that contains its address argument as read-only, and the arming bit drops back to zero. Lock flags stay set until a full reset, which stands in for nonvolatile state.

Two small state machines carry the state:
- The copy machine has states `CP_IDLE` and `CP_BUSY`. A copy command moves it from `CP_IDLE` to `CP_BUSY`. The storage done strobe moves it back to `CP_IDLE`.
- The arming machine has states `LK_DISARMED` and `LK_ARMED`. A control write with bit 6 set moves it to `LK_ARMED`. A control write with bit 6 clear, or any lock command, moves it from `LK_ARMED` back to `LK_DISARMED`.

Top module: `eeprom_lock_ctrl`

## Requirements
- R1: After reset the control register reads 00h and no block is locked.
- R2: The control register read value has the copy flag in bit 7, the arming bit in bit 6, the block 1 lock flag in bit 1 and the block 0 lock flag in bit 0. Bits 5 to 2 read 0.
- R3: A copy command sets the copy flag in the cycle after it is accepted. The flag stays set until the storage raises done, and it reads 0 from the cycle after that.
- R4: While the copy flag is 1, writes to addresses 20h to 3Fh give `ee_we` = 0.
- R5: A write to 07h sets the arming bit when data bit 6 is 1 and clears it when bit 6 is 0. The other written bits do not change the register.
- R6: A lock command while the arming bit is 0 changes no lock flag.
- R7: A lock command while the arming bit is 1 sets the flag of the block holding its address (20h–2Fh sets bit 0, 30h–3Fh sets bit 1). An address outside both blocks sets no flag. In every case the arming bit reads 0 in the next cycle.
- R8: While a block's flag is 1, writes to that block give `ee_we` = 0. An unlocked block still accepts writes.
- R9: Writes to addresses outside 20h–3Fh give `ee_we` = 1 whatever the copy and lock state.
- R10: Lock flags are cleared only by reset. Writing 07h does not clear them.
- R11: When a lock command and a write of 07h arrive in the same cycle while armed, the lock executes and the arming bit ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all flags |
| wr_req | input | 1 | Write request strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write data |
| copy_cmd | input | 1 | Copy-data command start strobe |
| mem_done | input | 1 | Storage reports copy finished |
| lock_cmd | input | 1 | Lock command strobe |
| lock_addr | input | 8 | Address whose block the lock command targets |
| ctrl_rdata | output | 8 | Read value of the control register at 07h |
| ee_we | output | 1 | Gated write enable to the array |
| ee_addr | output | 8 | Write address forwarded to the array |
| ee_wdata | output | 8 | Write data forwarded to the array |

## Verification
The embedded properties check on every cycle the following:
- the gate never enables a write into the array while a copy is running;
- out-of-range writes always pass;
- a copy command always raises the busy state;
- a lock command always leaves the arming machine disarmed;
- a disarmed lock command never changes a flag;
- lock flags never fall.

Only the bench scenarios show three things. The first is the register's bit layout as read back. The second is that each lock lands on the correct block. The third is the outcome of the same-cycle lock and arm-write collision. It also shows that a reset really wipes the sticky flags.

// File: rtl/eelk_pkg.sv
package eelk_pkg;
    typedef enum logic {CP_IDLE = 1'b0, CP_BUSY = 1'b1} copy_st_e;
    typedef enum logic {LK_DISARMED = 1'b0, LK_ARMED = 1'b1} arm_st_e;

    localparam int unsigned CTRL_BIT_COPY = 7;
    localparam int unsigned CTRL_BIT_ARM  = 6;
endpackage

// File: rtl/eelk_blk_dec.sv
module eelk_blk_dec #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BASE      = 32,
    parameter int unsigned BLK_BYTES = 16,
    parameter int unsigned NUM_BLK   = 2
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_BLK-1:0] hit
);
    for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
        localparam int unsigned LO = BASE + i * BLK_BYTES;
        localparam int unsigned HI = LO + BLK_BYTES;
        assign hit[i] = ({1'b0, addr} >= (ADDR_W+1)'(LO)) &&
                        ({1'b0, addr} <  (ADDR_W+1)'(HI));
    end
endmodule

// File: rtl/eelk_copy_fsm.sv
module eelk_copy_fsm
    import eelk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic copy_cmd,
    input  logic mem_done,
    output logic copy_busy
);
    copy_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CP_IDLE: if (copy_cmd) state_d = CP_BUSY;
            CP_BUSY: if (mem_done) state_d = CP_IDLE;
            default: state_d = CP_IDLE;
        endcase
    end

    always_comb begin
        copy_busy = (state_q == CP_BUSY);
    end

    // R3: an accepted copy command raises the busy state
    a_r3_copy_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_cmd && !copy_busy) |=> copy_busy);
    // R3: done ends the busy state
    a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_busy && mem_done) |=> !copy_busy);
endmodule

// File: rtl/eelk_arm_fsm.sv
module eelk_arm_fsm
    import eelk_pkg::*;
#(
    parameter int unsigned NUM_BLK = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic               ctrl_arm_val,
    input  logic               lock_cmd,
    input  logic [NUM_BLK-1:0] lock_hit,
    output logic               armed,
    output logic [NUM_BLK-1:0] blk_lock
);
    arm_st_e            state_q, state_d;
    logic [NUM_BLK-1:0] blk_q, blk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_DISARMED;
            blk_q   <= '0;
        end else begin
            state_q <= state_d;
            blk_q   <= blk_d;
        end
    end

    always_comb begin
        state_d = state_q;
        blk_d   = blk_q;
        unique case (state_q)
            LK_DISARMED: begin
                if (ctrl_wr && ctrl_arm_val) state_d = LK_ARMED;
            end
            LK_ARMED: begin
                if (lock_cmd) begin
                    blk_d   = blk_q | lock_hit;
                    state_d = LK_DISARMED;
                end else if (ctrl_wr && !ctrl_arm_val) begin
                    state_d = LK_DISARMED;
                end
            end
            default: state_d = LK_DISARMED;
        endcase
    end

    always_comb begin
        armed    = (state_q == LK_ARMED);
        blk_lock = blk_q;
    end

    // R7, R11: a lock command always leaves the machine disarmed
    a_r7_arm_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && lock_cmd) |=> !armed);
    // R6: a disarmed lock command leaves every flag as it was
    a_r6_disarmed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && lock_cmd) |=> $stable(blk_lock));
    // R10: flags never fall while out of reset
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_lock != '0) |=> ((blk_lock & $past(blk_lock)) == $past(blk_lock)));
endmodule

// File: rtl/eelk_wr_gate.sv
module eelk_wr_gate #(
    parameter int unsigned NUM_BLK = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [NUM_BLK-1:0] wr_hit,
    input  logic [NUM_BLK-1:0] blk_lock,
    input  logic               copy_busy,
    output logic               we
);
    logic in_array;
    logic hit_locked;

    always_comb begin
        in_array   = |wr_hit;
        hit_locked = |(wr_hit & blk_lock);
        we = wr_req && (!in_array || (!copy_busy && !hit_locked));
    end

    // R4: no array write while the copy runs
    a_r4_copy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_busy && wr_req && in_array) |-> !we);
    // R9: writes outside the array always pass
    a_r9_outside_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !in_array) |-> we);
    // R8: no write into a locked block
    a_r8_locked_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && hit_locked) |-> !we);
endmodule

// File: rtl/eeprom_lock_ctrl.sv
module eeprom_lock_ctrl
    import eelk_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CTRL_ADDR = 7,
    parameter int unsigned ARR_BASE  = 32,
    parameter int unsigned BLK_BYTES = 16,
    parameter int unsigned NUM_BLK   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              copy_cmd,
    input  logic              mem_done,
    input  logic              lock_cmd,
    input  logic [ADDR_W-1:0] lock_addr,
    output logic [DATA_W-1:0] ctrl_rdata,
    output logic              ee_we,
    output logic [ADDR_W-1:0] ee_addr,
    output logic [DATA_W-1:0] ee_wdata
);
    logic               copy_busy;
    logic               armed;
    logic [NUM_BLK-1:0] blk_lock;
    logic [NUM_BLK-1:0] wr_hit;
    logic [NUM_BLK-1:0] lock_hit;
    logic               ctrl_wr;

    assign ctrl_wr = wr_req && (wr_addr == ADDR_W'(CTRL_ADDR));

    eelk_blk_dec #(.ADDR_W(ADDR_W), .BASE(ARR_BASE), .BLK_BYTES(BLK_BYTES),
                   .NUM_BLK(NUM_BLK)) u_wr_dec (.addr(wr_addr), .hit(wr_hit));

    eelk_blk_dec #(.ADDR_W(ADDR_W), .BASE(ARR_BASE), .BLK_BYTES(BLK_BYTES),
                   .NUM_BLK(NUM_BLK)) u_lock_dec (.addr(lock_addr), .hit(lock_hit));

    eelk_copy_fsm u_copy (
        .clk(clk), .rst_n(rst_n), .copy_cmd(copy_cmd),
        .mem_done(mem_done), .copy_busy(copy_busy)
    );

    eelk_arm_fsm #(.NUM_BLK(NUM_BLK)) u_arm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .ctrl_arm_val(wr_data[CTRL_BIT_ARM]), .lock_cmd(lock_cmd),
        .lock_hit(lock_hit), .armed(armed), .blk_lock(blk_lock)
    );

    eelk_wr_gate #(.NUM_BLK(NUM_BLK)) u_gate (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_hit(wr_hit),
        .blk_lock(blk_lock), .copy_busy(copy_busy), .we(ee_we)
    );

    always_comb begin
        ctrl_rdata                = '0;
        ctrl_rdata[CTRL_BIT_COPY] = copy_busy;
        ctrl_rdata[CTRL_BIT_ARM]  = armed;
        ctrl_rdata[NUM_BLK-1:0]   = blk_lock;
    end

    assign ee_addr  = wr_addr;
    assign ee_wdata = wr_data;

    // R2: reserved bits always read zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[5:2] == 4'b0000);
endmodule

// File: tb/eeprom_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module eeprom_lock_ctrl_tb_top;
    localparam logic [2:0] OP_WR = 3'd0, OP_CPY = 3'd1, OP_DONE = 3'd2,
                           OP_LOCK = 3'd3, OP_NOP = 3'd4;
    localparam int NVEC = 19;
    // {op, addr, data, expected ee_we, expected register, requirement number}
    localparam logic [31:0] VEC [NVEC] = '{
        {OP_WR,   8'h25, 8'hAA, 1'b1, 8'h00, 4'd8},  // R8 unlocked writes
        {OP_WR,   8'h07, 8'h40, 1'b1, 8'h40, 4'd5},  // R5 arm
        {OP_WR,   8'h07, 8'h00, 1'b1, 8'h00, 4'd5},  // R5 disarm
        {OP_LOCK, 8'h25, 8'h00, 1'b0, 8'h00, 4'd6},  // R6 ignored
        {OP_WR,   8'h25, 8'h11, 1'b1, 8'h00, 4'd6},  // R6 still writable
        {OP_WR,   8'h07, 8'hC3, 1'b1, 8'h40, 4'd5},  // R5 only bit 6 taken
        {OP_LOCK, 8'h25, 8'h00, 1'b0, 8'h01, 4'd7},  // R7 block 0
        {OP_WR,   8'h2F, 8'h22, 1'b0, 8'h01, 4'd8},  // R8 locked
        {OP_WR,   8'h30, 8'h33, 1'b1, 8'h01, 4'd8},  // R8 other block
        {OP_LOCK, 8'h35, 8'h00, 1'b0, 8'h01, 4'd6},  // R6 disarmed
        {OP_WR,   8'h07, 8'h40, 1'b1, 8'h41, 4'd2},  // R2 layout
        {OP_LOCK, 8'h3F, 8'h00, 1'b0, 8'h03, 4'd7},  // R7 block 1
        {OP_WR,   8'h07, 8'h00, 1'b1, 8'h03, 4'd10}, // R10 flags kept
        {OP_WR,   8'h3F, 8'h44, 1'b0, 8'h03, 4'd8},  // R8 locked
        {OP_WR,   8'h10, 8'h55, 1'b1, 8'h03, 4'd9},  // R9 outside
        {OP_CPY,  8'h00, 8'h00, 1'b0, 8'h83, 4'd3},  // R3 copy set
        {OP_WR,   8'h40, 8'h66, 1'b1, 8'h83, 4'd9},  // R9 during copy
        {OP_NOP,  8'h00, 8'h00, 1'b0, 8'h83, 4'd3},  // R3 holds
        {OP_DONE, 8'h00, 8'h00, 1'b0, 8'h03, 4'd3}   // R3 cleared
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_req = 1'b0, copy_cmd = 1'b0, mem_done = 1'b0, lock_cmd = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, lock_addr = '0;
    logic [7:0] ctrl_rdata, ee_addr, ee_wdata;
    logic ee_we;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    eeprom_lock_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .copy_cmd(copy_cmd), .mem_done(mem_done),
        .lock_cmd(lock_cmd), .lock_addr(lock_addr), .ctrl_rdata(ctrl_rdata),
        .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata)
    );

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d,
                        input logic ewe, input logic [7:0] ereg, input int req);
        @(negedge clk);
        wr_req   = (op == OP_WR);
        copy_cmd = (op == OP_CPY);
        mem_done = (op == OP_DONE);
        lock_cmd = (op == OP_LOCK);
        wr_addr = a; wr_data = d; lock_addr = a;
        #1;
        if (op == OP_WR) chk(ee_we === ewe, req, "ee_we", {7'd0, ee_we}, {7'd0, ewe});
        @(posedge clk); #1;
        wr_req = 0; copy_cmd = 0; mem_done = 0; lock_cmd = 0;
        chk(ctrl_rdata === ereg, req, "ctrl_rdata", ctrl_rdata, ereg);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(ctrl_rdata === 8'h00, 1, "reset value", ctrl_rdata, 8'h00); // R1
        for (int i = 0; i < NVEC; i++)
            step(VEC[i][31:29], VEC[i][28:21], VEC[i][20:13], VEC[i][12],
                 VEC[i][11:4], int'(VEC[i][3:0]));

        // R10: reset wipes the locks
        do_reset();
        #1;
        chk(ctrl_rdata === 8'h00, 10, "after reset", ctrl_rdata, 8'h00);
        // R4: copy blocks both blocks, released by done
        step(OP_CPY,  8'h00, 8'h00, 1'b0, 8'h80, 3);
        step(OP_WR,   8'h22, 8'h01, 1'b0, 8'h80, 4);
        step(OP_WR,   8'h33, 8'h02, 1'b0, 8'h80, 4);
        step(OP_DONE, 8'h00, 8'h00, 1'b0, 8'h00, 3);
        step(OP_WR,   8'h22, 8'h03, 1'b1, 8'h00, 4);
        // R7: armed lock outside both blocks only disarms
        step(OP_WR,   8'h07, 8'h40, 1'b1, 8'h40, 5);
        step(OP_LOCK, 8'h50, 8'h00, 1'b0, 8'h00, 7);
        // R11: lock and arm write in the same cycle
        step(OP_WR,   8'h07, 8'h40, 1'b1, 8'h40, 5);
        @(negedge clk);
        wr_req = 1; wr_addr = 8'h07; wr_data = 8'h40;
        lock_cmd = 1; lock_addr = 8'h21;
        @(posedge clk); #1;
        wr_req = 0; lock_cmd = 0;
        chk(ctrl_rdata === 8'h01, 11, "collision", ctrl_rdata, 8'h01);
        // R1: no write enable without a request
        #1;
        chk(ee_we === 1'b0, 1, "idle ee_we", {7'd0, ee_we}, 8'h00);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R0 watchdog: actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule